// File: doc/BRIEF.md
# Incremental Quadratic Raster Evaluator

This block produces, for every pixel of a raster scan, the value of a bivariate second-order polynomial V(x,y) = A·x² + B·y² + C·x·y + D·x + E·y + F without any multiplier. The polynomial is split into a per-pixel part that grows with x and line-start terms that depend only on y. Two chained adders walk the x part one pixel per clock. The y-dependent terms live in a small coefficient store and are advanced in place at every line start, while the line is in horizontal retrace.

A host fills the coefficient store during vertical blanking with six words per field, precomputed from A..F. A raster timing source then sends a line strobe before each line and a pixel strobe for each active pixel. For each pixel the block returns a 32-bit wrapped value, a flag that is set when that value is not negative, and a valid strobe. The control sequence is held in a short microprogram. With interlace enabled, the store keeps two independent six-word banks, one per field, and a frame strobe picks which bank is in use.

Top module: `qexpr_raster_eval`

## Requirements
- R1: For each accepted pixel strobe, `valid_o` is high in the following cycle and `val_o` equals V(x,y). Here x counts accepted pixel strobes since the latest completed line setup, starting at 0, and y counts the line setups completed on the active bank since it was loaded, minus one.
- R2: When `valid_o` is high, `present_o` is 1 exactly when `val_o` is zero or positive in two's complement (sign bit 0).
- R3: All arithmetic is 32-bit two's complement and wraps modulo 2^32, so outputs match the polynomial evaluated modulo 2^32.
- R4: The six words of a bank are laid out as follows: word 0 = 2A, word 1 = 2B, word 2 = C, word 3 = A+D, word 4 = B+E, word 5 = F. Word addresses 6 and 7 hold no storage, and writes to them have no effect.
- R5: An accepted line strobe starts a 4-cycle setup. The following are ignored and produce no output: a pixel strobe in the same cycle as that line strobe, pixel strobes during the setup, and line strobes during the setup.
- R6: A line strobe while `vblank` is high is ignored: no setup runs, and the line terms are not advanced.
- R7: A host write takes effect only when `wr_en`, `load_en` and `vblank` are all high and no line setup is in progress. Any other write attempt leaves the stored coefficients unchanged.
- R8: With INTERLACE set, `wr_addr` bit 3 selects the bank (bit 3 = 1 for bank 1) and bits 2:0 select the word. A `frame_start` pulse latches `field` as the active bank. Each bank advances only its own terms, so one field's lines never disturb the other field's coefficients.
- R9: In a cycle after no accepted pixel strobe, `valid_o` is low and `val_o` keeps its previous value.
- R10: After reset, `val_o` is 0, `present_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame strobe; latches `field` as active bank |
| field | input | 1 | Field number sampled with `frame_start` |
| line_start | input | 1 | Line strobe, issued during horizontal retrace |
| pix_en | input | 1 | Active-pixel strobe, one per pixel, left to right |
| vblank | input | 1 | Vertical blanking indicator |
| load_en | input | 1 | Host coefficient-load enable |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | AW | Host word address ({bank, word} with interlace) |
| wr_data | input | W | Host write data |
| val_o | output | W | Polynomial value of the last accepted pixel |
| present_o | output | 1 | Set when that value is not negative |
| valid_o | output | 1 | Pulses one cycle after an accepted pixel strobe |

## Verification
Three pairs of events can fall in the same cycle: a pixel strobe with a line strobe, a host write with a microcode writeback, and a pixel strobe with the setup that follows a line strobe. The bench raises `line_start` and `pix_en` together, and checks that no output appears and that the following line still starts at x = 0 and advances y exactly once. It also raises `vblank`, `load_en` and `wr_en` in the middle of a setup, and confirms through every later pixel value that the host write was dropped and that the microcode writeback went through.

// File: rtl/qexpr_pkg.sv
package qexpr_pkg;

    localparam int COEF_WORDS = 6;
    localparam int UPC_W      = 3;

    // coefficient word slots inside one bank
    typedef enum logic [2:0] {
        W_A2 = 3'd0,   // 2A, per-pixel second difference
        W_B2 = 3'd1,   // 2B, per-line second difference
        W_C  = 3'd2,   // C, line step of first pixel difference
        W_D0 = 3'd3,   // first pixel difference at x=0 of current line
        W_DQ = 3'd4,   // line difference of line-start value
        W_Q  = 3'd5    // value at x=0 of current line
    } word_e;

    typedef enum logic [1:0] { D_HOLD, D_LOAD, D_ADD } dop_e;
    typedef enum logic [1:0] { V_HOLD, V_LOAD, V_ADD } vop_e;
    typedef enum logic [1:0] { S_NONE, S_ADD1, S_ADD2, S_DREG } wsrc_e;

    typedef struct packed {
        word_e  ra;     // read port A (adder-1 operand / diff load)
        word_e  rb;     // read port B (value load)
        dop_e   dop;
        vop_e   vop;
        wsrc_e  wsrc;
        word_e  wa;     // writeback slot
        logic   last;
    } uop_t;

    typedef struct packed {
        dop_e   dop;
        vop_e   vop;
        logic   step;   // accepted pixel this cycle
    } dp_ctl_t;

    // microprogram store, address 0 is the idle / pixel slot
    function automatic uop_t uc_fetch(input logic [UPC_W-1:0] a);
        uop_t u;
        u = '{ra: W_A2, rb: W_Q, dop: D_HOLD, vop: V_HOLD,
              wsrc: S_NONE, wa: W_Q, last: 1'b1};
        case (a)
            3'd0: u = '{ra: W_A2, rb: W_Q,  dop: D_ADD,  vop: V_ADD,
                        wsrc: S_NONE, wa: W_Q,  last: 1'b0};
            3'd1: u = '{ra: W_DQ, rb: W_Q,  dop: D_LOAD, vop: V_LOAD,
                        wsrc: S_NONE, wa: W_Q,  last: 1'b0};
            3'd2: u = '{ra: W_B2, rb: W_Q,  dop: D_ADD,  vop: V_HOLD,
                        wsrc: S_ADD2, wa: W_Q,  last: 1'b0};
            3'd3: u = '{ra: W_D0, rb: W_Q,  dop: D_LOAD, vop: V_HOLD,
                        wsrc: S_DREG, wa: W_DQ, last: 1'b0};
            3'd4: u = '{ra: W_C,  rb: W_Q,  dop: D_HOLD, vop: V_HOLD,
                        wsrc: S_ADD1, wa: W_D0, last: 1'b1};
            default: ;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/qexpr_coef_ram.sv
module qexpr_coef_ram
    import qexpr_pkg::*;
#(
    parameter int W     = 32,
    parameter int BANKS = 1,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bank,
    input  word_e         ra,
    input  word_e         rb,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          seq_we,
    input  word_e         seq_word,
    input  logic [W-1:0]  seq_data,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [W-1:0]  host_data
);
    localparam int DEPTH = BANKS * COEF_WORDS;
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0] mem [DEPTH];

    function automatic logic [IW-1:0] slot(input logic b, input logic [2:0] w);
        int s;
        s = ((BANKS > 1) && b) ? COEF_WORDS : 0;
        s = s + int'(w);
        return IW'(s);
    endfunction

    logic [2:0]    host_word;
    logic          host_bank;
    logic          host_ok;
    logic          wr_go;
    logic [IW-1:0] wr_idx;
    logic [W-1:0]  wr_dat;

    assign host_word = host_addr[2:0];
    assign host_bank = (BANKS > 1) ? host_addr[AW-1] : 1'b0;
    assign host_ok   = host_we && (host_word < 3'(COEF_WORDS));

    // microcode writeback owns the port whenever it writes
    always_comb begin
        wr_go  = seq_we || host_ok;
        wr_idx = seq_we ? slot(bank, seq_word) : slot(host_bank, host_word);
        wr_dat = seq_we ? seq_data : host_data;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (wr_go && (wr_idx == IW'(i)))
                mem[i] <= wr_dat;
        end
    end

    assign rd_a = mem[slot(bank, ra)];
    assign rd_b = mem[slot(bank, rb)];

endmodule

// File: rtl/qexpr_useq.sv
module qexpr_useq
    import qexpr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    line_start,
    input  logic    pix_en,
    input  logic    vblank,
    output logic    busy,
    output word_e   ra,
    output word_e   rb,
    output dp_ctl_t ctl,
    output logic    wb_en,
    output word_e   wb_word,
    output wsrc_e   wb_src
);
    logic [UPC_W-1:0] upc;
    uop_t             uop;
    logic             line_go;

    assign uop     = uc_fetch(upc);
    assign busy    = (upc != '0);
    assign line_go = line_start && !vblank && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            upc <= '0;
        else if (busy)
            upc <= uop.last ? '0 : upc + 1'b1;
        else if (line_go)
            upc <= UPC_W'(1);
    end

    always_comb begin
        ra       = uop.ra;
        rb       = uop.rb;
        ctl.step = !busy && pix_en && !line_go;
        if (busy) begin
            ctl.dop = uop.dop;
            ctl.vop = uop.vop;
        end else if (ctl.step) begin
            ctl.dop = uop.dop;
            ctl.vop = uop.vop;
        end else begin
            ctl.dop = D_HOLD;
            ctl.vop = V_HOLD;
        end
        wb_en   = busy && (uop.wsrc != S_NONE);
        wb_word = uop.wa;
        wb_src  = uop.wsrc;
    end

endmodule

// File: rtl/qexpr_datapath.sv
module qexpr_datapath
    import qexpr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  dp_ctl_t      ctl,
    input  wsrc_e        wb_src,
    input  logic [W-1:0] rd_a,
    input  logic [W-1:0] rd_b,
    output logic [W-1:0] wb_data,
    output logic [W-1:0] val_o,
    output logic         present_o,
    output logic         valid_o
);
    logic [W-1:0] dreg;   // running difference
    logic [W-1:0] vreg;   // running value
    logic [W-1:0] add1;
    logic [W-1:0] add2;

    assign add1 = dreg + rd_a;
    assign add2 = vreg + dreg;

    always_comb begin
        case (wb_src)
            S_ADD1:  wb_data = add1;
            S_ADD2:  wb_data = add2;
            S_DREG:  wb_data = dreg;
            default: wb_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dreg <= '0;
            vreg <= '0;
        end else begin
            case (ctl.dop)
                D_LOAD:  dreg <= rd_a;
                D_ADD:   dreg <= add1;
                default: dreg <= dreg;
            endcase
            case (ctl.vop)
                V_LOAD:  vreg <= rd_b;
                V_ADD:   vreg <= add2;
                default: vreg <= vreg;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            val_o     <= '0;
            present_o <= 1'b0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= ctl.step;
            if (ctl.step) begin
                val_o     <= vreg;
                present_o <= !vreg[W-1];
            end
        end
    end

endmodule

// File: rtl/qexpr_raster_eval.sv
module qexpr_raster_eval
    import qexpr_pkg::*;
#(
    parameter int  W         = 32,
    parameter bit  INTERLACE = 1'b0,
    localparam int BANKS     = INTERLACE ? 2 : 1,
    localparam int AW        = INTERLACE ? 4 : 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic          field,
    input  logic          line_start,
    input  logic          pix_en,
    input  logic          vblank,
    input  logic          load_en,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  val_o,
    output logic          present_o,
    output logic          valid_o
);
    logic         bank_q;
    logic         seq_busy;
    logic         host_wr_ok;
    word_e        ra, rb, wb_word;
    wsrc_e        wb_src;
    logic         wb_en;
    dp_ctl_t      ctl;
    logic [W-1:0] rd_a, rd_b, wb_data;

    always_ff @(posedge clk) begin
        if (rst)
            bank_q <= 1'b0;
        else if (frame_start)
            bank_q <= field;
    end

    assign host_wr_ok = wr_en && load_en && vblank && !seq_busy;

    qexpr_useq u_seq (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .pix_en     (pix_en),
        .vblank     (vblank),
        .busy       (seq_busy),
        .ra         (ra),
        .rb         (rb),
        .ctl        (ctl),
        .wb_en      (wb_en),
        .wb_word    (wb_word),
        .wb_src     (wb_src)
    );

    qexpr_coef_ram #(.W(W), .BANKS(BANKS), .AW(AW)) u_ram (
        .clk       (clk),
        .rst       (rst),
        .bank      (bank_q),
        .ra        (ra),
        .rb        (rb),
        .rd_a      (rd_a),
        .rd_b      (rd_b),
        .seq_we    (wb_en),
        .seq_word  (wb_word),
        .seq_data  (wb_data),
        .host_we   (host_wr_ok),
        .host_addr (wr_addr),
        .host_data (wr_data)
    );

    qexpr_datapath #(.W(W)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .wb_src    (wb_src),
        .rd_a      (rd_a),
        .rd_b      (rd_b),
        .wb_data   (wb_data),
        .val_o     (val_o),
        .present_o (present_o),
        .valid_o   (valid_o)
    );

endmodule

// File: rtl/qexpr_raster_eval_chk.sv
module qexpr_raster_eval_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         line_start,
    input logic         pix_en,
    input logic         vblank,
    input logic         busy,
    input logic [W-1:0] val_o,
    input logic         valid_o
);
    AST_OUT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(pix_en)); // R1

    AST_SETUP_DROPS_PIX: assert property (@(posedge clk) disable iff (rst)
        busy |=> !valid_o); // R5

    AST_COLLIDE_DROPS_PIX: assert property (@(posedge clk) disable iff (rst)
        (line_start && pix_en && !busy && !vblank) |=> !valid_o); // R5

    AST_SETUP_KICK: assert property (@(posedge clk) disable iff (rst)
        (line_start && !busy && !vblank) |=> busy); // R5

    AST_SETUP_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> busy ##1 busy ##1 busy ##1 busy ##1 !busy); // R5

    AST_VBLANK_NO_SETUP: assert property (@(posedge clk) disable iff (rst)
        (line_start && vblank && !busy) |=> !busy); // R6

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> (!valid_o && $stable(val_o))); // R9

endmodule

bind qexpr_raster_eval qexpr_raster_eval_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_start (line_start),
    .pix_en     (pix_en),
    .vblank     (vblank),
    .busy       (seq_busy),
    .val_o      (val_o),
    .valid_o    (valid_o)
);

// File: tb/qexpr_raster_eval_tb.sv
module qexpr_raster_eval_tb;

    localparam int W    = 32;
    localparam int AW   = 4;
    localparam int NPIX = 16;
    localparam int NLIN = 8;

    typedef struct packed {
        logic [31:0] a, b, c, d, e, f;
        logic        bank;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{32'd1, 32'd2, 32'hFFFF_FFFF, 32'd3, 32'hFFFF_FFFB, 32'd7, 1'b0},
        '{32'hFFFF_FFFD, 32'd1, 32'd4, 32'hFFFF_FFEC, 32'd2, 32'hFFFF_FF9C, 1'b1},
        '{32'd0, 32'd0, 32'd0, 32'd1, 32'd16, 32'd0, 1'b0},
        '{32'h4000_0000, 32'h3000_0001, 32'h7FFF_FFFF, 32'd5, 32'hFFFF_FFF9,
          32'h7FFF_FFF0, 1'b1},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd0, 32'd50, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_start = 1'b0, field = 1'b0;
    logic          line_start = 1'b0, pix_en = 1'b0;
    logic          vblank = 1'b1, load_en = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  val_o;
    logic          present_o, valid_o;

    int   n_vec = 0;
    int   n_bad = 0;
    vec_t coef [2];
    int   ycnt [2];
    logic [31:0] last_exp = '0;

    always #5 clk = ~clk;

    qexpr_raster_eval #(.W(W), .INTERLACE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .field(field),
        .line_start(line_start), .pix_en(pix_en), .vblank(vblank),
        .load_en(load_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .val_o(val_o), .present_o(present_o),
        .valid_o(valid_o)
    );

    function automatic logic [31:0] vmod(vec_t v, int x, int y);
        logic [31:0] xx, yy;
        xx = 32'(x);
        yy = 32'(y);
        return v.a*xx*xx + v.b*yy*yy + v.c*xx*yy + v.d*xx + v.e*yy + v.f;
    endfunction

    function automatic logic [31:0] word_of(vec_t v, int w);
        case (w)
            0: return v.a << 1;
            1: return v.b << 1;
            2: return v.c;
            3: return v.a + v.d;
            4: return v.b + v.e;
            default: return v.f;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(logic bk, int w, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = {bk, 3'(w)}; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R4, R8: load six words of a bank during vertical blanking
    task automatic load_bank(vec_t v);
        vblank = 1'b1; load_en = 1'b1;
        for (int w = 0; w < 6; w++) host_write(v.bank, w, word_of(v, w));
        load_en = 1'b0;
        coef[v.bank] = v;
        ycnt[v.bank] = 0;
    endtask

    task automatic start_field(logic bk);
        @(negedge clk); frame_start = 1'b1; field = bk;
        @(negedge clk); frame_start = 1'b0; vblank = 1'b0;
    endtask

    task automatic line_setup();
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R1, R2, R3: consecutive pixels compared against direct evaluation
    task automatic run_pixels(logic bk);
        logic [31:0] e;
        for (int x = 0; x <= NPIX; x++) begin
            @(negedge clk);
            if (x > 0) begin
                e = vmod(coef[bk], x - 1, ycnt[bk]);
                chk("R1 value", val_o, e);
                chk("R2 present", {31'd0, present_o}, {31'd0, !e[31]});
                chk("R1 valid", {31'd0, valid_o}, 32'd1);
                last_exp = e;
            end
            pix_en = (x < NPIX);
        end
        ycnt[bk]++;
    endtask

    task automatic run_line(logic bk);
        line_setup();
        run_pixels(bk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset state
        chk("R10 val", val_o, 32'd0);
        chk("R10 present", {31'd0, present_o}, 32'd0);
        chk("R10 valid", {31'd0, valid_o}, 32'd0);
        @(negedge clk); rst = 1'b0;

        // table walk: each vector is one frame on its bank (R1 R2 R3 R4)
        for (int k = 0; k < NVEC; k++) begin
            load_bank(VECS[k]);
            start_field(VECS[k].bank);
            for (int y = 0; y < NLIN; y++) run_line(VECS[k].bank);
        end

        // R8: interleaved fields keep separate line terms
        load_bank(VECS[0]);
        load_bank(VECS[1]);
        start_field(1'b0);
        for (int y = 0; y < 3; y++) run_line(1'b0);
        vblank = 1'b1;
        start_field(1'b1);
        for (int y = 0; y < 3; y++) run_line(1'b1);
        vblank = 1'b1;
        start_field(1'b0);
        for (int y = 0; y < 2; y++) run_line(1'b0);

        // R6: line strobe during vblank does not advance y
        vblank = 1'b1;
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        repeat (6) @(negedge clk);
        vblank = 1'b0;
        run_line(1'b0);

        // R5: pixel with accepted line strobe, and strobes inside setup
        @(negedge clk); line_start = 1'b1; pix_en = 1'b1;
        @(negedge clk); line_start = 1'b1; pix_en = 1'b1;
        chk("R5 collide valid", {31'd0, valid_o}, 32'd0);
        @(negedge clk); line_start = 1'b0; pix_en = 1'b0;
        chk("R5 setup valid", {31'd0, valid_o}, 32'd0);
        repeat (2) @(negedge clk);
        run_pixels(1'b0);

        // R9: output holds while no pixels arrive
        repeat (3) @(negedge clk);
        chk("R9 hold value", val_o, last_exp);
        chk("R9 valid low", {31'd0, valid_o}, 32'd0);

        // R7: rejected writes (no vblank, no load enable, during setup)
        load_en = 1'b1; vblank = 1'b0;
        host_write(1'b0, 5, 32'hDEAD_BEEF);
        load_en = 1'b0; vblank = 1'b1;
        host_write(1'b0, 0, 32'h1234_5678);
        // R4: addresses 6 and 7 carry no storage
        load_en = 1'b1;
        host_write(1'b0, 6, 32'hAAAA_AAAA);
        host_write(1'b0, 7, 32'h5555_5555);
        load_en = 1'b0; vblank = 1'b0;
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
        vblank = 1'b1; load_en = 1'b1; wr_en = 1'b1;
        wr_addr = {1'b0, 3'd5}; wr_data = 32'hBAD0_0BAD;
        @(negedge clk); wr_en = 1'b0; load_en = 1'b0; vblank = 1'b0;
        repeat (2) @(negedge clk);
        run_pixels(1'b0);
        run_line(1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule